// File: doc/BRIEF.md
# Serial DAC Input Front End

This block is the digital receive side of a serial-input digital-to-analog converter. A fast system clock oversamples four slow control lines: an active-low frame strobe, a serial bit clock, a serial data line and an active-low load strobe. A frame opens when the frame strobe falls. After that, the data line is sampled on each falling edge of the bit clock. A gated counter admits exactly sixteen of those edges, so the bit clock may run continuously or come in bursts.

When a word is complete it reaches the converter's code register in one of two ways. If the load strobe was low when the frame opened, the register takes the word at once. If the load strobe was high, the word is held and the register takes it on the next falling edge of the load strobe. Only the code register drives the output. Each synchronous load raises a one-cycle update pulse. An active-low asynchronous clear forces the code to zero and drops any held word.

A parameter sets the resolution to 16 or 14 bits. In both cases the frame is 16 bits long.

Top module: `sdac_front`

## Requirements
- R1: After `rst_ni` is released, `dac_code_o` is zero and `upd_o` is low.
- R2: Bits arrive MSB first. In 16-bit resolution the first sampled bit lands in code bit 15 and the 16th lands in code bit 0.
- R3: A frame takes exactly 16 falling bit-clock edges. Further edges before the frame strobe rises do not change the code.
- R4: If `ldac_ni` is low when the frame strobe falls, the code register loads the word. The new code and the update pulse appear on the 4th system-clock edge after the 16th bit-clock fall reaches the input pins, and not earlier.
- R5: If `ldac_ni` is high when the frame strobe falls, completing the frame leaves the code unchanged. The next falling edge of `ldac_ni` loads the word.
- R6: A falling edge of `ldac_ni` with no complete word held leaves the code unchanged and gives no update pulse.
- R7: If the frame strobe rises before 16 bits have arrived, the partial word is dropped. The code is unchanged and no update pulse is given.
- R8: In 14-bit resolution the frame is still 16 bits. The code is taken from the first 14 bits, MSB first, and the last two bits are ignored.
- R9: `upd_o` is high for exactly one system-clock cycle per load. The code never changes without it, except by the clear.
- R10: While `clr_ni` is low, `dac_code_o` is zero, independent of the clock. A held word is dropped, so a later `ldac_ni` fall loads nothing.
- R11: In deferred mode the most recently completed word is the one loaded.
- R12: The update mode is fixed when the frame opens. A change of `ldac_ni` during the frame does not change the mode of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low asynchronous clear of the code register |
| sync_ni | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial bit clock; data is sampled on its falling edge |
| sdin_i | input | 1 | Serial data, MSB first |
| ldac_ni | input | 1 | Active-low load strobe; also selects the update mode at frame start |
| dac_code_o | output | RES_BITS | Code register driving the converter |
| upd_o | output | 1 | One-cycle pulse on each load of the code register |

## Verification
Each pin passes through a two-flop synchronizer. An edge detector follows, then the shift stage, then the code register. A bit-clock fall driven on the pins therefore shows up in the code four system-clock edges later, and the update pulse drops one edge after that. The bench drives and samples on the falling system-clock edge. The latency check reads the old code after three edges, the new code after four, and the dropped pulse after five. Every other check waits at least six edges after its stimulus, so the synchronizer delay cannot hide a missing or early load. Update pulses are counted over the whole run, and each check compares how many arrived against how many were expected.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    UPD_AUTO  = 1'b0,
    UPD_DEFER = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg <= {DEPTH{RST_VAL[b]}};
      else         stg <= {stg[DEPTH-2:0], d_i[b]};
    end
    assign q_o[b] = stg[DEPTH-1];
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int unsigned FLEN = FRAME_LEN,
  localparam int unsigned CW = $clog2(FLEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_n_i,
  input  logic            sclk_i,
  input  logic            sdin_i,
  input  logic            ldac_n_i,
  output logic [FLEN-1:0] word_o,
  output logic            done_o,
  output upd_mode_e       mode_o,
  output logic [CW-1:0]   cnt_o
);
  logic          sync_q, sclk_q, active;
  logic          frame_start, sclk_fall;
  logic [CW-1:0] cnt;

  assign frame_start = sync_q & ~sync_n_i;
  assign sclk_fall   = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b1;
      sclk_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      word_o <= '0;
      done_o <= 1'b0;
      mode_o <= UPD_AUTO;
    end else begin
      sync_q <= sync_n_i;
      sclk_q <= sclk_i;
      done_o <= 1'b0;
      if (frame_start) begin
        active <= 1'b1;
        cnt    <= '0;
        mode_o <= upd_mode_e'(ldac_n_i);
      end else if (sync_n_i) begin
        active <= 1'b0;  // early rise drops partial word
      end else if (active && sclk_fall && cnt != CW'(FLEN)) begin
        word_o <= {word_o[FLEN-2:0], sdin_i};
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(FLEN - 1)) done_o <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int unsigned FLEN = FRAME_LEN,
  parameter int unsigned RES_BITS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ldac_n_i,
  input  logic [FLEN-1:0]     word_i,
  input  logic                done_i,
  input  upd_mode_e           mode_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                upd_o,
  output logic                pending_o
);
  logic                ldac_q, ldac_fall;
  logic [RES_BITS-1:0] held;

  assign ldac_fall = ldac_q & ~ldac_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ldac_q    <= 1'b1;
      code_o    <= '0;
      held      <= '0;
      upd_o     <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      ldac_q <= ldac_n_i;
      upd_o  <= 1'b0;
      if (done_i && mode_i == UPD_AUTO) begin
        code_o    <= word_i[FLEN-1 -: RES_BITS];
        upd_o     <= 1'b1;
        pending_o <= 1'b0;
      end else if (done_i) begin
        held      <= word_i[FLEN-1 -: RES_BITS];
        pending_o <= 1'b1;
      end else if (ldac_fall && pending_o) begin
        code_o    <= held;
        upd_o     <= 1'b1;
        pending_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int unsigned RES_BITS = 16,
  localparam int unsigned CW = $clog2(FRAME_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_ni,
  input  logic                sync_ni,
  input  logic                sclk_i,
  input  logic                sdin_i,
  input  logic                ldac_ni,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                upd_o
);
  logic [3:0]           pins_s;
  logic [FRAME_LEN-1:0] shift_word;
  logic                 word_done, pending, latch_rst_n;
  upd_mode_e            frame_mode;
  logic [CW-1:0]        bit_cnt;

  // order: sync, sclk, sdin, ldac
  sdac_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sync_ni, sclk_i, sdin_i, ldac_ni}),
    .q_o   (pins_s)
  );

  sdac_shifter #(.FLEN(FRAME_LEN)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_n_i(pins_s[3]),
    .sclk_i  (pins_s[2]),
    .sdin_i  (pins_s[1]),
    .ldac_n_i(pins_s[0]),
    .word_o  (shift_word),
    .done_o  (word_done),
    .mode_o  (frame_mode),
    .cnt_o   (bit_cnt)
  );

  assign latch_rst_n = rst_ni & clr_ni;

  sdac_latch #(.FLEN(FRAME_LEN), .RES_BITS(RES_BITS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (latch_rst_n),
    .ldac_n_i (pins_s[0]),
    .word_i   (shift_word),
    .done_i   (word_done),
    .mode_i   (frame_mode),
    .code_o   (dac_code_o),
    .upd_o    (upd_o),
    .pending_o(pending)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
  import sdac_pkg::*;
#(
  parameter int unsigned RES_BITS = 16,
  localparam int unsigned CW = $clog2(FRAME_LEN + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clr_ni,
  input logic [RES_BITS-1:0]  dac_code_o,
  input logic                 upd_o,
  input logic                 word_done,
  input upd_mode_e            frame_mode,
  input logic [CW-1:0]        bit_cnt,
  input logic [FRAME_LEN-1:0] shift_word
);
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CW'(FRAME_LEN)); // R3
  AST_DONE_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |-> bit_cnt == CW'(FRAME_LEN)); // R3
  AST_AUTO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (word_done && frame_mode == UPD_AUTO) |=>
      (upd_o && dac_code_o == $past(shift_word[FRAME_LEN-1 -: RES_BITS]))); // R4
  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (word_done && frame_mode == UPD_DEFER) |=> !upd_o); // R5
  AST_CODE_NEEDS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (!$stable(dac_code_o) && $past(clr_ni)) |-> upd_o); // R9
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> dac_code_o == '0); // R10
endmodule

bind sdac_front sdac_front_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_ni    (clr_ni),
  .dac_code_o(dac_code_o),
  .upd_o     (upd_o),
  .word_done (word_done),
  .frame_mode(frame_mode),
  .bit_cnt   (bit_cnt),
  .shift_word(shift_word)
);

// File: tb/sdac_front_bench.sv
module sdac_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0, ldac_n = 1'b1;
  logic [15:0] code16;
  logic [13:0] code14;
  logic        upd16, upd14;
  int n_chk = 0, n_fail = 0, upd16_cnt = 0, upd14_cnt = 0;
  logic [15:0] exp16 = '0;
  logic [13:0] exp14 = '0;

  always #10 clk = ~clk;

  sdac_front #(.RES_BITS(16)) u_sdac_front (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .sync_ni(sync_n),
    .sclk_i(sclk), .sdin_i(sdin), .ldac_ni(ldac_n),
    .dac_code_o(code16), .upd_o(upd16)
  );
  sdac_front #(.RES_BITS(14)) u_sdac_front14 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .sync_ni(sync_n),
    .sclk_i(sclk), .sdin_i(sdin), .ldac_ni(ldac_n),
    .dac_code_o(code14), .upd_o(upd14)
  );

  always @(posedge clk) begin
    if (upd16) upd16_cnt <= upd16_cnt + 1;
    if (upd14) upd14_cnt <= upd14_cnt + 1;
  end

  // {deferred, word}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 16'hA5C3}, {1'b1, 16'h1234}, {1'b0, 16'hFFFF}, {1'b1, 16'h8001}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic b);
    sclk = 1'b1; sdin = b; tick(3);
    sclk = 1'b0; tick(3);
  endtask

  task automatic frame(logic [15:0] w, logic defer, int npulse);
    ldac_n = defer; tick(3);
    sync_n = 1'b0; tick(4);
    for (int i = 0; i < npulse; i++) pulse(i < 16 ? w[15 - i] : 1'b1);
    tick(4);
    sync_n = 1'b1; tick(4);
  endtask

  task automatic chk_codes(string req);
    chk({req, " code16"}, 32'(code16), 32'(exp16));
    chk({req, " code14"}, 32'(code14), 32'(exp14));
  endtask

  initial begin
    tick(3);
    n_chk++;
    if (upd16 !== 1'b0) begin n_fail++; $display("FAIL R1 upd actual=%b expected=0", upd16); end
    chk_codes("R1");
    rst_n = 1'b1; tick(3);

    for (int v = 0; v < 4; v++) begin
      automatic int u0 = upd16_cnt;
      automatic logic defer = VEC[v][16];
      automatic logic [15:0] w = VEC[v][15:0];
      frame(w, defer, 16);
      if (defer) begin
        chk_codes("R5 deferred hold");
        ldac_n = 1'b0; tick(6);
      end
      exp16 = w; exp14 = w[15:2];
      chk_codes(defer ? "R5 deferred load" : "R2 R8 auto load");
      chk("R9 one pulse", 32'(upd16_cnt - u0), 32'd1);
    end

    // R4 latency
    begin
      automatic logic [15:0] w = 16'h3C5A;
      ldac_n = 1'b0; tick(3);
      sync_n = 1'b0; tick(4);
      for (int i = 0; i < 15; i++) pulse(w[15 - i]);
      sclk = 1'b1; sdin = w[0]; tick(3);
      sclk = 1'b0; tick(3);
      chk("R4 old code at 3", 32'(code16), 32'(exp16));
      tick(1);
      exp16 = w; exp14 = w[15:2];
      chk("R4 new code at 4", 32'(code16), 32'(exp16));
      chk("R4 upd at 4", 32'(upd16), 32'd1);
      tick(1);
      chk("R9 upd dropped", 32'(upd16), 32'd0);
      tick(4); sync_n = 1'b1; tick(4);
    end

    // R6 load strobe with nothing held
    begin
      automatic int u0 = upd16_cnt;
      ldac_n = 1'b1; tick(4); ldac_n = 1'b0; tick(6);
      chk_codes("R6");
      chk("R6 no pulse", 32'(upd16_cnt - u0), 32'd0);
    end

    // R7 aborted frame, then a load strobe
    begin
      automatic int u0 = upd16_cnt;
      frame(16'hFFFF, 1'b0, 10);
      chk_codes("R7");
      frame(16'hFFFF, 1'b1, 10);
      ldac_n = 1'b0; tick(6);
      chk_codes("R7 deferred abort");
      chk("R7 no pulse", 32'(upd16_cnt - u0), 32'd0);
    end

    // R3 extra edges locked out; R8 trailing bits ignored
    frame(16'h0F0F, 1'b0, 20);
    exp16 = 16'h0F0F; exp14 = 14'h03C3;
    chk_codes("R3 R8 lockout");

    // R12 mode fixed at frame start, R11 latest word wins
    begin
      automatic int u0 = upd16_cnt;
      ldac_n = 1'b1; tick(3);
      sync_n = 1'b0; tick(4);
      for (int i = 0; i < 16; i++) begin
        if (i == 8) ldac_n = 1'b0;
        pulse(1'(16'h7E81 >> (15 - i)));
      end
      tick(4); sync_n = 1'b1; tick(4);
      chk_codes("R12 no load");
      frame(16'hC0DE, 1'b1, 16);
      chk_codes("R5 second defer");
      ldac_n = 1'b0; tick(6);
      exp16 = 16'hC0DE; exp14 = 14'h3037;
      chk_codes("R11 latest word");
      chk("R11 one pulse", 32'(upd16_cnt - u0), 32'd1);
    end

    // R10 asynchronous clear drops held word
    begin
      automatic int u0;
      frame(16'h5555, 1'b1, 16);
      @(negedge clk); #3 clr_n = 1'b0; #2;
      exp16 = '0; exp14 = '0;
      chk_codes("R10 async zero");
      tick(2); clr_n = 1'b1; tick(2);
      u0 = upd16_cnt;
      ldac_n = 1'b0; tick(6);
      chk_codes("R10 held dropped");
      chk("R10 no pulse", 32'(upd16_cnt - u0), 32'd0);
    end

    chk("R9 equal pulses both widths", 32'(upd14_cnt), 32'(upd16_cnt));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule